// File: doc/BRIEF.md
# Pipelined Byte-Write Burst SRAM

A synchronous single-port static RAM for use as a local data store or cache data array. Each word is split into byte lanes of eight data bits and one parity bit. Address, control and write data are captured on a clock edge. A write finishes on the next edge. A read loads an output register on the next edge, so read data is visible one full cycle after the address was sampled.

A write can target the whole word or selected lanes only. The whole-word write input takes priority. Lane writes need both a shared byte-write qualifier and that lane's own enable.

Three chip-select inputs let several of these blocks share one read-data bus. A new selection turns on the output drive after two edges. A deselection turns it off after one. The output enable gates the drive without waiting for a clock. A sleep input stops all activity and blanks the outputs at once, and the stored data is kept.

Top module: `burst_sram_pipe`

## Requirements
- R1: While reset is asserted and after it is released, `rd_drive` is 0 and `rd_data` is all zeros until a read has been enabled.
- R2: When `wr_all_n` is 0 in a selected cycle, every lane of the addressed word is written with `wr_data`, whatever `wr_byte_n` and `lane_wr_n` are.
- R3: With `wr_all_n` at 1, lane i (bits [9i+8:9i]) is written only when `wr_byte_n` is 0 and `lane_wr_n[i]` is 0. With `wr_byte_n` at 1 the cycle is a read and nothing is written, even when lane enables are 0.
- R4: For a read whose address is sampled at clock edge k, `rd_data` shows the stored word after edge k+1 and not earlier.
- R5: After the chip becomes selected for reads at edge k, `rd_drive` is 0 after edge k and 1 after edge k+1. A deselection sampled at an edge sets `rd_drive` to 0 after that same edge.
- R6: `out_en_n` at 1 forces `rd_drive` to 0 and `rd_data` to zero without a clock edge. Returning it to 0 restores the drive at once.
- R7: A cycle is selected only when `sel_pri_n` is 0, `sel_sec_n` is 0 and `sel_hi` is 1. Any other combination writes nothing and turns the drive off.
- R8: While `sleep` is 1, `rd_drive` is 0 with no clock edge needed. No write takes effect, including a write sampled in the cycle before sleep rose. Stored contents are kept.
- R9: After `sleep` falls, the first selected read restarts the enable sequence: the drive is off after the first edge and on after the second.
- R10: Bit 9i+8 of each lane is its parity bit. It is stored and cleared together with the other eight bits of that lane.
- R11: A read of an address just written returns the new lanes, and lanes that were not written keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request, active high |
| sel_pri_n | input | 1 | Primary select, active low |
| sel_sec_n | input | 1 | Secondary select, active low |
| sel_hi | input | 1 | Select, active high |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | LANES*(LANE_BITS+1) | Write data, lane i at bits [9i+8:9i] |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| rd_data | output | LANES*(LANE_BITS+1) | Read data, zero while not driven |
| rd_drive | output | 1 | High while the read data bus is driven |

## Verification
The bench uses the default parameters: a 16-word array with four 9-bit lanes. This makes both end addresses (0 and 15) reachable, and every lane and parity bit can be checked. A table of whole-word and lane writes, each read back, checks lane merging and the priority of the whole-word write. Directed sequences then check the enable timing around selection changes, invalid select combinations, the unclocked output enable, and a write caught by sleep in flight.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Operation held in the first pipeline stage.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bsram_op_e;

endpackage

// File: rtl/bsram_ctl.sv
module bsram_ctl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_pri_n,
  input  logic              sel_sec_n,
  input  logic              sel_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sel_now,
  output bsram_op_e         s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_mask,
  output logic [DATA_W-1:0] s1_wdata
);

  logic [LANES-1:0]  mask_d;
  bsram_op_e         op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  mask_nx;
  logic [DATA_W-1:0] wdata_d;

  // Select decode: all three selects must agree, and sleep blocks the cycle.
  assign sel_now = !sel_pri_n && !sel_sec_n && sel_hi && !sleep;

  // Two-tier lane decode: the whole-word write overrides, otherwise the
  // qualifier and the lane enable must both be active.
  for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
    assign mask_d[g] = !wr_all_n || (!wr_byte_n && !lane_wr_n[g]);
  end

  always_comb begin
    op_d    = OP_IDLE;
    addr_d  = s1_addr;
    mask_nx = s1_mask;
    wdata_d = s1_wdata;
    if (sel_now) begin
      op_d    = (|mask_d) ? OP_WRITE : OP_READ;
      addr_d  = addr;
      mask_nx = mask_d;
      wdata_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_mask  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_op <= op_d;
      if (sel_now) begin
        s1_addr  <= addr_d;
        s1_mask  <= mask_nx;
        s1_wdata <= wdata_d;
      end
    end
  end

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && !wr_all_n) |=> (s1_op == OP_WRITE && (&s1_mask))); // R2

  AST_LANES_NEED_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && wr_all_n && wr_byte_n) |=> (s1_op == OP_READ)); // R3

  AST_BAD_SELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_hi || sel_pri_n || sel_sec_n) |=> (s1_op == OP_IDLE)); // R7

  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (s1_op == OP_IDLE)); // R8

endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  bsram_op_e         s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [LANES-1:0]  s1_mask,
  input  logic [DATA_W-1:0] s1_wdata,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_d;

  // A stage-one operation commits only if sleep is low at this edge.
  assign wr_fire = (s1_op == OP_WRITE) && !sleep;
  assign rd_fire = (s1_op == OP_READ)  && !sleep;

  // Storage: lane-masked write, no reset on the array.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int i = 0; i < LANES; i++) begin
        if (s1_mask[i]) begin
          mem[s1_addr][i*LANE_W +: LANE_W] <= s1_wdata[i*LANE_W +: LANE_W];
        end
      end
    end
  end

  // Output register: second pipeline stage.
  always_comb begin
    rd_d = rd_q;
    if (rd_fire) begin
      rd_d = mem[s1_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_fire) begin
      rd_q <= rd_d;
    end
  end

  AST_OUTREG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op != OP_READ) |=> $stable(rd_q)); // R4

endmodule

// File: rtl/bsram_oe_pipe.sv
module bsram_oe_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic sel_now,
  input  logic s1_read,
  input  logic out_en_n,
  output logic drive
);

  logic en_q;
  logic en_d;

  // Enable needs a read already in stage one and a still-valid selection,
  // so turning on takes two edges while turning off takes one.
  assign en_d = s1_read && sel_now && !sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  // Output enable and sleep act without a clock.
  assign drive = en_q && !out_en_n && !sleep;

  AST_ENABLE_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(s1_read)); // R5

  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> !en_q); // R5

  AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !en_q); // R9

endmodule

// File: rtl/burst_sram_pipe.sv
module burst_sram_pipe
  import bsram_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  localparam int LANE_W   = LANE_BITS + 1,
  localparam int DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_pri_n,
  input  logic              sel_sec_n,
  input  logic              sel_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  logic              sel_now;
  bsram_op_e         s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [DATA_W-1:0] s1_wdata;
  logic [DATA_W-1:0] rd_q;

  bsram_ctl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .sel_pri_n (sel_pri_n),
    .sel_sec_n (sel_sec_n),
    .sel_hi    (sel_hi),
    .addr      (addr),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_wr_n (lane_wr_n),
    .wr_data   (wr_data),
    .sel_now   (sel_now),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .s1_mask   (s1_mask),
    .s1_wdata  (s1_wdata)
  );

  bsram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .s1_mask  (s1_mask),
    .s1_wdata (s1_wdata),
    .rd_q     (rd_q)
  );

  bsram_oe_pipe i_oe (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .sel_now  (sel_now),
    .s1_read  (s1_op == OP_READ),
    .out_en_n (out_en_n),
    .drive    (rd_drive)
  );

  assign rd_data = rd_drive ? rd_q : '0;

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_drive); // R8

endmodule

// File: tb/test_burst_sram_pipe.sv
module test_burst_sram_pipe;

  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int DATA_W = 36;

  logic              clk;
  logic              rst_n;
  logic              sleep;
  logic              sel_pri_n;
  logic              sel_sec_n;
  logic              sel_hi;
  logic [ADDR_W-1:0] addr;
  logic              wr_all_n;
  logic              wr_byte_n;
  logic [LANES-1:0]  lane_wr_n;
  logic [DATA_W-1:0] wr_data;
  logic              out_en_n;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  burst_sram_pipe i_burst_sram_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .sel_pri_n (sel_pri_n),
    .sel_sec_n (sel_sec_n),
    .sel_hi    (sel_hi),
    .addr      (addr),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_wr_n (lane_wr_n),
    .wr_data   (wr_data),
    .out_en_n  (out_en_n),
    .rd_data   (rd_data),
    .rd_drive  (rd_drive)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  a;
    logic        gw_n;
    logic        bw_n;
    logic [3:0]  ln_n;
    logic [35:0] wd;
    logic [35:0] exp_d;
  } vec_t;

  // Write (or non-write) then read back; expected word from the lane rules.
  localparam vec_t VEC [8] = '{
    '{4'd3,  1'b0, 1'b1, 4'b1111, 36'h123456789, 36'h123456789},
    '{4'd3,  1'b1, 1'b0, 4'b1110, 36'hFFFFFFFFF, 36'h1234567FF},
    '{4'd3,  1'b1, 1'b1, 4'b0000, 36'h000000000, 36'h1234567FF},
    '{4'd3,  1'b1, 1'b0, 4'b0111, 36'h000000000, 36'h0034567FF},
    '{4'd9,  1'b0, 1'b0, 4'b1111, 36'hABCDE0123, 36'hABCDE0123},
    '{4'd9,  1'b1, 1'b0, 4'b1010, 36'h000000000, 36'hAB8020000},
    '{4'd0,  1'b1, 1'b0, 4'b0000, 36'h0DEADBEEF, 36'h0DEADBEEF},
    '{4'd15, 1'b0, 1'b1, 4'b0101, 36'hFFFFFFFFF, 36'hFFFFFFFFF}
  };
  localparam string TAGS [8] = '{"R2", "R3", "R3", "R10", "R2", "R3", "R11", "R2"};

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic deselect();
    sel_pri_n = 1'b1;
    sel_sec_n = 1'b1;
    sel_hi    = 1'b0;
    wr_all_n  = 1'b1;
    wr_byte_n = 1'b1;
    lane_wr_n = '1;
  endtask

  task automatic put_op(input logic [3:0] a, input logic gw_n, input logic bw_n,
                        input logic [3:0] ln_n, input logic [35:0] wd);
    sel_pri_n = 1'b0;
    sel_sec_n = 1'b0;
    sel_hi    = 1'b1;
    addr      = a;
    wr_all_n  = gw_n;
    wr_byte_n = bw_n;
    lane_wr_n = ln_n;
    wr_data   = wd;
  endtask

  task automatic put_read(input logic [3:0] a);
    put_op(a, 1'b1, 1'b1, 4'b1111, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    sleep    = 1'b0;
    out_en_n = 1'b0;
    addr     = '0;
    wr_data  = '0;
    deselect();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 drive", {35'd0, rd_drive}, 36'd0);
    check("R1 data", rd_data, 36'd0);
    rst_n = 1'b1;
    step();
    check("R1 drive after release", {35'd0, rd_drive}, 36'd0);

    // Table walk: op, read, read, then sample after the second read edge.
    for (int i = 0; i < 8; i++) begin
      put_op(VEC[i].a, VEC[i].gw_n, VEC[i].bw_n, VEC[i].ln_n, VEC[i].wd);
      step();
      put_read(VEC[i].a);
      step();
      step();
      check({TAGS[i], " drive"}, {35'd0, rd_drive}, 36'd1);
      check({TAGS[i], " R11 readback"}, rd_data, VEC[i].exp_d);
    end

    // R4: latency; reading word 15 continues, switch address to 9
    put_read(4'd9);
    step();
    check("R4 old data after one edge", rd_data, 36'hFFFFFFFFF);
    step();
    check("R4 new data after two edges", rd_data, 36'hAB8020000);

    // R5: deselect turns drive off after one edge
    deselect();
    step();
    check("R5 deselect off", {35'd0, rd_drive}, 36'd0);
    step();
    put_read(4'd0);
    step();
    check("R5 off after first edge", {35'd0, rd_drive}, 36'd0);
    step();
    check("R5 on after second edge", {35'd0, rd_drive}, 36'd1);
    check("R5 data", rd_data, 36'h0DEADBEEF);

    // R6: unclocked output enable
    out_en_n = 1'b1;
    #1;
    check("R6 drive gated", {35'd0, rd_drive}, 36'd0);
    check("R6 data gated", rd_data, 36'd0);
    out_en_n = 1'b0;
    #1;
    check("R6 drive restored", {35'd0, rd_drive}, 36'd1);

    // R7: invalid select combinations write nothing
    put_op(4'd0, 1'b0, 1'b0, 4'b0000, 36'd0);
    sel_hi = 1'b0;
    step();
    sel_hi = 1'b1;
    sel_sec_n = 1'b1;
    step();
    sel_sec_n = 1'b0;
    sel_pri_n = 1'b1;
    step();
    check("R7 drive off", {35'd0, rd_drive}, 36'd0);
    put_read(4'd0);
    step();
    step();
    check("R7 word unchanged", rd_data, 36'h0DEADBEEF);

    // R8: write sampled just before sleep rises must not land
    put_op(4'd15, 1'b0, 1'b1, 4'b1111, 36'd0);
    step();
    sleep = 1'b1;
    #1;
    check("R8 drive off at once", {35'd0, rd_drive}, 36'd0);
    step();
    put_op(4'd15, 1'b0, 1'b1, 4'b1111, 36'd0);
    step();
    check("R8 drive off asleep", {35'd0, rd_drive}, 36'd0);
    sleep = 1'b0;
    put_read(4'd15);
    step();
    check("R9 off after first edge", {35'd0, rd_drive}, 36'd0);
    step();
    check("R9 on after second edge", {35'd0, rd_drive}, 36'd1);
    check("R8 contents kept", rd_data, 36'hFFFFFFFFF);

    // R10/R11: lane 3 parity still cleared at word 3
    put_read(4'd3);
    step();
    step();
    check("R10 parity lane", rd_data, 36'h0034567FF);

    finish_run();
  end

endmodule